// File: doc/BRIEF.md
# Load Queue with Memory-Ordering Violation Search

This block keeps the in-flight loads of an out-of-order core in a circular queue. Loads arrive in program order with a sequence number. Each load also records where the store queue tail stood when it was allocated, or a flag saying that no store was older. A load's address arrives later, when the load executes. Loads leave the queue in two ways:

- from the head, when commit reports the youngest committed sequence number;
- from the tail, one per cycle, when a squash names a sequence number and the load is younger than it.

When a store executes, the block compares the store's address with every load from the store's recorded load index up to the tail, in parallel. The comparison is coarse: only the address bits above bit 7 are used. The oldest matching load becomes the pending violator and the store receives a fault one cycle later. The violator is held until it is read out. While it is pending, no new search is made. If a squash removes the violator load, the pending violator is dropped.

The block also reports a free-entry count for dispatch. This is the smaller of the free load slots and the free store slots.

Top module: `load_order_queue`

## Requirements
- R1: The queue holds at most LQ_N loads in LQ_N+1 slots. allocReady is low when LQ_N loads are held, and an allocation request made then changes nothing.
- R2: allocIdx shows the slot the next load will take. Slots are handed out 0, 1, … LQ_N and then wrap back to 0.
- R3: While commitValid is high and squashValid is low, one head load is retired per cycle if its sequence number is less than or equal to commitSeq. Retiring stops at the first head load that is younger.
- R4: While squashValid is high, one load is removed from the tail end per cycle if its sequence number is greater than squashSeq, and allocIdx moves back to the freed slot. Allocation and commit requests are ignored during a squash.
- R5: A store check is made on chkValid with a start slot and an address. Only loads from the start slot up to, but not including, the tail are compared. Two addresses match when they are equal after a right shift by 8. chkDone and chkFault appear one cycle after chkValid.
- R6: When several loads match, the one nearest the start slot (the oldest) is chosen. Its slot and sequence number appear on violIdx and violSeq.
- R7: While a violator is pending, a store check performs no search. chkFault stays low and the violator outputs stay unchanged.
- R8: violRead returns the pending violator and clears violPending at the next edge.
- R9: A load whose address has not been written never matches, whatever address the store carries.
- R10: freeCount equals min(LQ_N − held loads, SQ_N − sqUsed).
- R11: If a squash removes the load that is the pending violator, violPending is cleared.
- R12: The violator outputs carry the store tag recorded at allocation. violNoOlder is 1 when the load was allocated while the store queue was empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Allocate one load at the tail |
| allocSeq | input | SEQ_W | Sequence number of the new load |
| allocSqEmpty | input | 1 | Store queue empty at allocation |
| allocSqTail | input | SQ_IDX_W | Store queue tail at allocation |
| allocReady | output | 1 | Queue can take a load |
| allocIdx | output | IDX_W | Slot the next load takes |
| addrValid | input | 1 | Write an executed load's address |
| addrIdx | input | IDX_W | Slot of that load |
| addrValue | input | ADDR_W | Executed address |
| commitValid | input | 1 | Commit report valid |
| commitSeq | input | SEQ_W | Youngest committed sequence number |
| squashValid | input | 1 | Squash in progress |
| squashSeq | input | SEQ_W | Loads younger than this are removed |
| chkValid | input | 1 | Store check request |
| chkStartIdx | input | IDX_W | First load slot to compare |
| chkAddr | input | ADDR_W | Store address |
| chkDone | output | 1 | Check result valid |
| chkFault | output | 1 | Check found a violation |
| violRead | input | 1 | Read and clear the violator |
| violPending | output | 1 | A violator is held |
| violIdx | output | IDX_W | Violator slot |
| violSeq | output | SEQ_W | Violator sequence number |
| violSqTag | output | SQ_IDX_W | Violator's recorded store tag |
| violNoOlder | output | 1 | Violator had no older store |
| sqUsed | input | CNT_W | Loads-side view of store queue occupancy |
| loadCount | output | CNT_W | Loads held |
| freeCount | output | CNT_W | Free entries reported to dispatch |

## Verification
A head or tail pointer that slips shows on allocIdx and loadCount in the very next cycle. It also shows later, because commit or squash stops on the wrong entry. A wrong range mask or a wrong priority in the search shows one cycle after chkValid: chkFault is wrong, or violIdx and violSeq name the wrong load. A violator register that fails to hold or to clear shows as a change on the violator outputs across later checks, reads or squashes. The bench checks each of these right after the cycle that should have caused it.

// File: rtl/lqg_pkg.sv
package lqg_pkg;
  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic doAlloc;   // write a new load into the tail slot
    logic doRetire;  // free the head slot
    logic doDrop;    // free the slot just before the tail
  } lqStrobe_t;
endpackage

// File: rtl/lqg_ctrl.sv
module lqg_ctrl
  import lqg_pkg::*;
#(
  parameter int LQ_N  = 4,
  parameter int SQ_N  = 4,
  parameter int SEQ_W = 16,
  localparam int SLOTS = LQ_N + 1,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int MAXN  = (LQ_N > SQ_N) ? LQ_N : SQ_N,
  localparam int CNT_W = $clog2(MAXN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             allocValid,
  input  logic             commitValid,
  input  logic [SEQ_W-1:0] commitSeq,
  input  logic             squashValid,
  input  logic [SEQ_W-1:0] squashSeq,
  input  logic [SEQ_W-1:0] headSeq,
  input  logic [SEQ_W-1:0] lastSeq,
  input  logic [CNT_W-1:0] sqUsed,
  output lqStrobe_t        strobe,
  output logic [IDX_W-1:0] headIdx,
  output logic [IDX_W-1:0] tailIdx,
  output logic [IDX_W-1:0] lastIdx,
  output logic [CNT_W-1:0] loadCount,
  output logic             allocReady,
  output logic [CNT_W-1:0] freeCount
);
  localparam logic [IDX_W-1:0] TOP_SLOT = IDX_W'(SLOTS - 1);

  logic isEmpty;
  logic [CNT_W-1:0] lqFree, sqFree;

  assign isEmpty    = (loadCount == '0);
  assign allocReady = (loadCount != CNT_W'(LQ_N));
  assign lastIdx    = (tailIdx == '0) ? TOP_SLOT : tailIdx - 1'b1;

  always_comb begin
    strobe.doDrop   = squashValid && !isEmpty && (lastSeq > squashSeq);
    strobe.doRetire = !squashValid && commitValid && !isEmpty && (headSeq <= commitSeq);
    strobe.doAlloc  = !squashValid && allocValid && allocReady;
  end

  assign lqFree    = CNT_W'(LQ_N) - loadCount;
  assign sqFree    = CNT_W'(SQ_N) - sqUsed;
  assign freeCount = (lqFree < sqFree) ? lqFree : sqFree;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      headIdx   <= '0;
      tailIdx   <= '0;
      loadCount <= '0;
    end else begin
      if (strobe.doRetire)
        headIdx <= (headIdx == TOP_SLOT) ? '0 : headIdx + 1'b1;
      if (strobe.doDrop)
        tailIdx <= lastIdx;
      else if (strobe.doAlloc)
        tailIdx <= (tailIdx == TOP_SLOT) ? '0 : tailIdx + 1'b1;
      loadCount <= loadCount + CNT_W'(strobe.doAlloc)
                 - CNT_W'(strobe.doRetire) - CNT_W'(strobe.doDrop);
    end
  end
endmodule

// File: rtl/lqg_data.sv
module lqg_data
  import lqg_pkg::*;
#(
  parameter int LQ_N        = 4,
  parameter int SEQ_W       = 16,
  parameter int ADDR_W      = 32,
  parameter int SQ_IDX_W    = 3,
  parameter int MATCH_SHIFT = 8,
  localparam int SLOTS = LQ_N + 1,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  lqStrobe_t           strobe,
  input  logic [IDX_W-1:0]    headIdx,
  input  logic [IDX_W-1:0]    tailIdx,
  input  logic [IDX_W-1:0]    lastIdx,
  input  logic [SEQ_W-1:0]    allocSeq,
  input  logic                allocSqEmpty,
  input  logic [SQ_IDX_W-1:0] allocSqTail,
  input  logic                addrValid,
  input  logic [IDX_W-1:0]    addrIdx,
  input  logic [ADDR_W-1:0]   addrValue,
  input  logic                chkValid,
  input  logic [IDX_W-1:0]    chkStartIdx,
  input  logic [ADDR_W-1:0]   chkAddr,
  input  logic                violRead,
  output logic [SEQ_W-1:0]    headSeq,
  output logic [SEQ_W-1:0]    lastSeq,
  output logic                chkDone,
  output logic                chkFault,
  output logic                violPending,
  output logic [IDX_W-1:0]    violIdx,
  output logic [SEQ_W-1:0]    violSeq,
  output logic [SQ_IDX_W-1:0] violSqTag,
  output logic                violNoOlder
);
  logic [SEQ_W-1:0]    entSeq    [SLOTS];
  logic [ADDR_W-1:0]   entAddr   [SLOTS];
  logic                entAddrOk [SLOTS];
  logic [SQ_IDX_W-1:0] entSqTag  [SLOTS];
  logic                entNoOld  [SLOTS];

  assign headSeq = entSeq[headIdx];
  assign lastSeq = entSeq[lastIdx];

  // Parallel compare, masked to the circular range [start, tail), oldest first
  logic             hit;
  logic [IDX_W-1:0] hitIdx;
  always_comb begin
    logic live;
    live   = 1'b1;
    hit    = 1'b0;
    hitIdx = '0;
    for (int k = 0; k < SLOTS; k++) begin
      int pos;
      logic [IDX_W-1:0] slot;
      pos = int'(chkStartIdx) + k;
      if (pos >= SLOTS) pos = pos - SLOTS;
      slot = IDX_W'(pos);
      if (slot == tailIdx) live = 1'b0;
      if (live && !hit && entAddrOk[slot] &&
          (entAddr[slot][ADDR_W-1:MATCH_SHIFT] == chkAddr[ADDR_W-1:MATCH_SHIFT])) begin
        hit    = 1'b1;
        hitIdx = slot;
      end
    end
  end

  logic takeViol;
  assign takeViol = chkValid && !violPending && hit;

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_ent
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          entSeq[g]    <= '0;
          entAddr[g]   <= '0;
          entAddrOk[g] <= 1'b0;
          entSqTag[g]  <= '0;
          entNoOld[g]  <= 1'b0;
        end else if (strobe.doAlloc && tailIdx == IDX_W'(g)) begin
          entSeq[g]    <= allocSeq;
          entAddrOk[g] <= 1'b0;
          entSqTag[g]  <= allocSqEmpty ? '0 : allocSqTail;
          entNoOld[g]  <= allocSqEmpty;
        end else if ((strobe.doRetire && headIdx == IDX_W'(g)) ||
                     (strobe.doDrop && lastIdx == IDX_W'(g))) begin
          entAddrOk[g] <= 1'b0;
        end else if (addrValid && addrIdx == IDX_W'(g)) begin
          entAddr[g]   <= addrValue;
          entAddrOk[g] <= 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chkDone     <= 1'b0;
      chkFault    <= 1'b0;
      violPending <= 1'b0;
      violIdx     <= '0;
      violSeq     <= '0;
      violSqTag   <= '0;
      violNoOlder <= 1'b0;
    end else begin
      chkDone  <= chkValid;
      chkFault <= takeViol;
      if (takeViol) begin
        violPending <= 1'b1;
        violIdx     <= hitIdx;
        violSeq     <= entSeq[hitIdx];
        violSqTag   <= entSqTag[hitIdx];
        violNoOlder <= entNoOld[hitIdx];
      end else if (violPending &&
                   (violRead || (strobe.doDrop && lastIdx == violIdx))) begin
        violPending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/load_order_queue.sv
module load_order_queue
  import lqg_pkg::*;
#(
  parameter int LQ_N        = 4,
  parameter int SQ_N        = 4,
  parameter int SEQ_W       = 16,
  parameter int ADDR_W      = 32,
  parameter int SQ_IDX_W    = 3,
  parameter int MATCH_SHIFT = 8,
  localparam int SLOTS = LQ_N + 1,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int MAXN  = (LQ_N > SQ_N) ? LQ_N : SQ_N,
  localparam int CNT_W = $clog2(MAXN + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                allocValid,
  input  logic [SEQ_W-1:0]    allocSeq,
  input  logic                allocSqEmpty,
  input  logic [SQ_IDX_W-1:0] allocSqTail,
  output logic                allocReady,
  output logic [IDX_W-1:0]    allocIdx,
  input  logic                addrValid,
  input  logic [IDX_W-1:0]    addrIdx,
  input  logic [ADDR_W-1:0]   addrValue,
  input  logic                commitValid,
  input  logic [SEQ_W-1:0]    commitSeq,
  input  logic                squashValid,
  input  logic [SEQ_W-1:0]    squashSeq,
  input  logic                chkValid,
  input  logic [IDX_W-1:0]    chkStartIdx,
  input  logic [ADDR_W-1:0]   chkAddr,
  output logic                chkDone,
  output logic                chkFault,
  input  logic                violRead,
  output logic                violPending,
  output logic [IDX_W-1:0]    violIdx,
  output logic [SEQ_W-1:0]    violSeq,
  output logic [SQ_IDX_W-1:0] violSqTag,
  output logic                violNoOlder,
  input  logic [CNT_W-1:0]    sqUsed,
  output logic [CNT_W-1:0]    loadCount,
  output logic [CNT_W-1:0]    freeCount
);
  lqStrobe_t        strobe;
  logic [IDX_W-1:0] headIdx, tailIdx, lastIdx;
  logic [SEQ_W-1:0] headSeq, lastSeq;

  assign allocIdx = tailIdx;

  lqg_ctrl #(.LQ_N(LQ_N), .SQ_N(SQ_N), .SEQ_W(SEQ_W)) u_ctrl (
    .clk, .rst_n, .allocValid, .commitValid, .commitSeq, .squashValid, .squashSeq,
    .headSeq, .lastSeq, .sqUsed, .strobe, .headIdx, .tailIdx, .lastIdx,
    .loadCount, .allocReady, .freeCount
  );

  lqg_data #(.LQ_N(LQ_N), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .SQ_IDX_W(SQ_IDX_W),
             .MATCH_SHIFT(MATCH_SHIFT)) u_data (
    .clk, .rst_n, .strobe, .headIdx, .tailIdx, .lastIdx, .allocSeq, .allocSqEmpty,
    .allocSqTail, .addrValid, .addrIdx, .addrValue, .chkValid, .chkStartIdx, .chkAddr,
    .violRead, .headSeq, .lastSeq, .chkDone, .chkFault, .violPending, .violIdx,
    .violSeq, .violSqTag, .violNoOlder
  );
endmodule

// File: rtl/load_order_queue_chk.sv
module load_order_queue_chk #(
  parameter int LQ_N  = 4,
  parameter int IDX_W = 3,
  parameter int SEQ_W = 16,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             allocValid,
  input logic             allocReady,
  input logic             commitValid,
  input logic             squashValid,
  input logic             chkValid,
  input logic             chkDone,
  input logic             chkFault,
  input logic             violRead,
  input logic             violPending,
  input logic [IDX_W-1:0] violIdx,
  input logic [SEQ_W-1:0] violSeq,
  input logic [CNT_W-1:0] loadCount
);
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    loadCount <= CNT_W'(LQ_N));

  assert_full_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (allocValid && !allocReady && !commitValid && !squashValid)
      |=> (loadCount == $past(loadCount)));

  assert_squash_no_growth_R4: assert property (@(posedge clk) disable iff (!rst_n)
    squashValid |=> (loadCount <= $past(loadCount)));

  assert_done_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chkValid |=> chkDone);

  assert_fault_records_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chkFault |-> violPending);

  assert_pending_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chkValid && violPending) |=> !chkFault);

  assert_viol_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (violPending && !violRead && !squashValid)
      |=> (violPending && $stable(violIdx) && $stable(violSeq)));

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (violPending && violRead) |=> !violPending);
endmodule

bind load_order_queue load_order_queue_chk #(
  .LQ_N(LQ_N), .IDX_W(IDX_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .allocValid(allocValid), .allocReady(allocReady),
  .commitValid(commitValid), .squashValid(squashValid), .chkValid(chkValid),
  .chkDone(chkDone), .chkFault(chkFault), .violRead(violRead),
  .violPending(violPending), .violIdx(violIdx), .violSeq(violSeq),
  .loadCount(loadCount)
);

// File: tb/load_order_queue_bench.sv
`timescale 1ns/1ps
module load_order_queue_bench;
  localparam int LQ_N = 4, SEQ_W = 16, ADDR_W = 32, SQ_IDX_W = 3;
  localparam int IDX_W = 3, CNT_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic allocValid = 0, allocSqEmpty = 0, addrValid = 0, commitValid = 0;
  logic squashValid = 0, chkValid = 0, violRead = 0;
  logic [SEQ_W-1:0] allocSeq = '0, commitSeq = '0, squashSeq = '0;
  logic [SQ_IDX_W-1:0] allocSqTail = '0;
  logic [IDX_W-1:0] addrIdx = '0, chkStartIdx = '0;
  logic [ADDR_W-1:0] addrValue = '0, chkAddr = '0;
  logic [CNT_W-1:0] sqUsed = '0;
  logic allocReady, chkDone, chkFault, violPending, violNoOlder;
  logic [IDX_W-1:0] allocIdx, violIdx;
  logic [SEQ_W-1:0] violSeq;
  logic [SQ_IDX_W-1:0] violSqTag;
  logic [CNT_W-1:0] loadCount, freeCount;

  load_order_queue u_load_order_queue (.*);

  int nChecks = 0, nFails = 0;

  task automatic expect_eq(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic push(logic [SEQ_W-1:0] s, logic noOld, logic [SQ_IDX_W-1:0] tag);
    allocValid = 1; allocSeq = s; allocSqEmpty = noOld; allocSqTail = tag;
    tick(); allocValid = 0;
  endtask

  task automatic setAddr(logic [IDX_W-1:0] i, logic [ADDR_W-1:0] a);
    addrValid = 1; addrIdx = i; addrValue = a; tick(); addrValid = 0;
  endtask

  task automatic storeCheck(logic [IDX_W-1:0] s, logic [ADDR_W-1:0] a);
    chkValid = 1; chkStartIdx = s; chkAddr = a; tick(); chkValid = 0;
  endtask

  task automatic t_reset();
    expect_eq("R1 reset count", 32'(loadCount), 0);
    expect_eq("R1 reset ready", 32'(allocReady), 1);
    expect_eq("R8 reset pending", 32'(violPending), 0);
    expect_eq("R5 reset done", 32'(chkDone), 0);
    expect_eq("R10 free sq empty", 32'(freeCount), 4);
    sqUsed = 3; #1;
    expect_eq("R10 free sq limited", 32'(freeCount), 1);
    sqUsed = 0;
  endtask

  task automatic t_fill();
    expect_eq("R2 idx0", 32'(allocIdx), 0);
    push(16'd10, 1'b1, 3'd0);
    expect_eq("R2 idx1", 32'(allocIdx), 1);
    push(16'd20, 1'b0, 3'd3);
    push(16'd30, 1'b0, 3'd2);
    push(16'd40, 1'b0, 3'd5);
    expect_eq("R1 full count", 32'(loadCount), 4);
    expect_eq("R1 full ready", 32'(allocReady), 0);
    push(16'd99, 1'b0, 3'd0);
    expect_eq("R1 alloc ignored when full", 32'(loadCount), 4);
    expect_eq("R1 tail unchanged when full", 32'(allocIdx), 4);
    sqUsed = 1; #1;
    expect_eq("R10 free lq limited", 32'(freeCount), 0);
    sqUsed = 0;
    setAddr(3'd0, 32'h1000);
    setAddr(3'd1, 32'h2000);
    setAddr(3'd3, 32'h2010);
  endtask

  task automatic t_search();
    storeCheck(3'd2, 32'h0000_0044);
    expect_eq("R9 unset addr no match done", 32'(chkDone), 1);
    expect_eq("R9 unset addr no match", 32'(chkFault), 0);
    storeCheck(3'd2, 32'h1000);
    expect_eq("R5 out of range no match", 32'(chkFault), 0);
    storeCheck(3'd0, 32'h20FF);
    expect_eq("R5 coarse match fault", 32'(chkFault), 1);
    expect_eq("R6 oldest idx", 32'(violIdx), 1);
    expect_eq("R6 oldest seq", 32'(violSeq), 20);
    expect_eq("R12 sq tag", 32'(violSqTag), 3);
    expect_eq("R12 no-older flag", 32'(violNoOlder), 0);
    storeCheck(3'd0, 32'h1000);
    expect_eq("R7 pending done", 32'(chkDone), 1);
    expect_eq("R7 pending no fault", 32'(chkFault), 0);
    expect_eq("R7 violator kept", 32'(violIdx), 1);
    violRead = 1; tick(); violRead = 0;
    expect_eq("R8 read clears", 32'(violPending), 0);
    storeCheck(3'd0, 32'h1080);
    expect_eq("R12 no-older violator", 32'(violNoOlder), 1);
    expect_eq("R6 head violator idx", 32'(violIdx), 0);
    violRead = 1; tick(); violRead = 0;
    storeCheck(3'd2, 32'h2000);
    expect_eq("R5 later load fault", 32'(chkFault), 1);
    expect_eq("R6 violator seq 40", 32'(violSeq), 40);
  endtask

  task automatic t_squash();
    squashValid = 1; squashSeq = 16'd25; allocValid = 1; allocSeq = 16'd77;
    commitValid = 1; commitSeq = 16'd100;
    tick();
    expect_eq("R11 squash clears violator", 32'(violPending), 0);
    expect_eq("R4 first drop", 32'(loadCount), 3);
    tick(); tick();
    squashValid = 0; allocValid = 0; commitValid = 0;
    expect_eq("R4 stops at older", 32'(loadCount), 2);
    expect_eq("R4 tail moved back", 32'(allocIdx), 2);
  endtask

  task automatic t_commit_wrap();
    commitValid = 1; commitSeq = 16'd15; tick(); tick(); commitValid = 0;
    expect_eq("R3 retire only older", 32'(loadCount), 1);
    push(16'd50, 1'b0, 3'd1);
    push(16'd60, 1'b0, 3'd1);
    expect_eq("R2 last slot", 32'(allocIdx), 4);
    push(16'd70, 1'b0, 3'd1);
    expect_eq("R2 wrap to 0", 32'(allocIdx), 0);
    expect_eq("R1 full after wrap", 32'(allocReady), 0);
    commitValid = 1; commitSeq = 16'd55; tick(); tick(); tick(); commitValid = 0;
    expect_eq("R3 retire to 50", 32'(loadCount), 2);
    push(16'd80, 1'b0, 3'd1);
    expect_eq("R2 after wrap", 32'(allocIdx), 1);
    expect_eq("R3 count after", 32'(loadCount), 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_search();
    t_squash();
    t_commit_wrap();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule